// File: doc/BRIEF.md
# Card Clock and Bit-Time Generator

This block produces the clock driven to each of several smart card slots and the bit-time (elementary time unit) tick consumed by the card serial port. Each slot has its own integer divider of the system clock, so the two card clocks run at independent rates. Firmware can freeze either card clock at a chosen level, high or low, and release it later. The freeze never produces a shortened pulse.

The bit time is a whole number of card clock periods. It is taken from a single configuration byte that holds a clock-rate code and a baud-adjust code in the standard smart card encodings. The tick counts rising edges of whichever slot clock is currently selected. The serial port can restart the count at any moment, for example to align it to a detected start bit. The default configuration gives 372 card clocks per bit, which is the length used while the card sends its answer to reset.

Top module: `scclk_etu_gen`

## Requirements
- R1: While `rst` is high every `card_clk` bit and `etu_tick` are 0. In the first cycle after `rst` is released, every `card_clk` bit is 1.
- R2: A card clock with divider value P repeats every P system cycles. It is high for floor(P/2) of those cycles and low for the rest. A divider value of 0 or 1 behaves as 2.
- R3: A new divider value is taken only when a card clock period begins. The period already running completes at its old length.
- R4: The slots are independent. Changing one slot's divider, or freezing its clock, leaves the other slot's clock unchanged.
- R5: `fd_cfg[7:4]` is the clock-rate code F and `fd_cfg[3:0]` is the baud-adjust code D. The bit time in card clocks is floor(F/D). F codes 0..6 give 372, 372, 558, 744, 1116, 1488, 1860. F codes 9..13 give 512, 768, 1024, 1536, 2048. D codes 1..9 give 1, 2, 4, 8, 16, 32, 64, 12, 20.
- R6: Reserved codes fall back independently of each other. An F code of 7, 8, 14 or 15 counts as 372, and a D code of 0 or 10..15 counts as 1.
- R7: `etu_tick` is high for exactly one cycle. It is asserted in the cycle after the rising edge of the selected card clock that completes a bit time.
- R8: `etu_restart` clears the bit-time count and suppresses any tick in the following cycle. A rising edge in the same cycle as the restart is not counted.
- R9: When `card_stop[i]` is high, slot i freezes at the next edge that takes its line to the level on `stop_lvl[i]` (1 = high, 0 = low). The clock then holds that level while the request stays high, and it resumes counting once the request is removed.
- R10: `if_sel` selects the slot whose card clock rising edges advance the bit-time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | NUM_IF x DIV_W | Per-slot divider value in system cycles |
| card_stop | input | NUM_IF | Per-slot request to freeze the card clock |
| stop_lvl | input | NUM_IF | Per-slot level at which to freeze (1 high, 0 low) |
| fd_cfg | input | 8 | Clock-rate code (upper nibble) and baud-adjust code (lower nibble) |
| if_sel | input | SEL_W | Slot whose clock drives the bit-time count |
| etu_restart | input | 1 | Restart the bit-time count |
| card_clk | output | NUM_IF | Card clock to each slot |
| etu_tick | output | 1 | One-cycle pulse at the end of each bit time |

## Verification
The sensitive coincidence is an `etu_restart` that arrives in the same cycle as the rising card clock edge that would complete a bit time. The bench uses the shortest bit time (five clocks) on a divide-by-two slot. It counts rising edges from the previous tick and raises the restart exactly in the cycle where the fifth edge appears. It then checks that no tick follows, and that the next tick comes only after a full five further edges. A second overlap, a freeze request that lands on a period boundary where a new divider value is loaded, is covered by the checker properties on the freeze level and hold.

// File: rtl/scetu_pkg.sv
package scetu_pkg;

    localparam int unsigned ETU_W   = 12;
    localparam int unsigned FCODE_W = 4;
    localparam int unsigned DCODE_W = 4;
    localparam logic [ETU_W-1:0] ETU_DEFAULT = ETU_W'(372);

    typedef enum logic {
        DIV_RUN  = 1'b0,
        DIV_HELD = 1'b1
    } div_state_e;

    typedef struct packed {
        logic [FCODE_W-1:0] f_code;
        logic [DCODE_W-1:0] d_code;
    } fd_cfg_t;

    function automatic logic [11:0] f_lookup(input logic [FCODE_W-1:0] code);
        logic [11:0] f;
        case (code)
            4'd2:    f = 12'd558;
            4'd3:    f = 12'd744;
            4'd4:    f = 12'd1116;
            4'd5:    f = 12'd1488;
            4'd6:    f = 12'd1860;
            4'd9:    f = 12'd512;
            4'd10:   f = 12'd768;
            4'd11:   f = 12'd1024;
            4'd12:   f = 12'd1536;
            4'd13:   f = 12'd2048;
            default: f = 12'd372;
        endcase
        return f;
    endfunction

    function automatic logic [6:0] d_lookup(input logic [DCODE_W-1:0] code);
        logic [6:0] d;
        case (code)
            4'd2:    d = 7'd2;
            4'd3:    d = 7'd4;
            4'd4:    d = 7'd8;
            4'd5:    d = 7'd16;
            4'd6:    d = 7'd32;
            4'd7:    d = 7'd64;
            4'd8:    d = 7'd12;
            4'd9:    d = 7'd20;
            default: d = 7'd1;
        endcase
        return d;
    endfunction

    function automatic logic [ETU_W-1:0] etu_len(input fd_cfg_t fd);
        logic [11:0] f;
        logic [11:0] d;
        f = f_lookup(fd.f_code);
        d = 12'(d_lookup(fd.d_code));
        return ETU_W'(f / d);
    endfunction

endpackage

// File: rtl/scclk_div.sv
module scclk_div
    import scetu_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             stop_req,
    input  logic             stop_high,
    output logic             card_clk,
    output logic             rise_p
);
    localparam logic [DIV_W-1:0] MIN_PER = DIV_W'(2);

    div_state_e       st_q, st_n;
    logic [DIV_W-1:0] per_q, half_q, cnt_q;
    logic [DIV_W-1:0] per_n, half_n, cnt_n, div_ok;
    logic             clk_n, rise_evt, fall_evt, wrap;

    assign div_ok = (div_i < MIN_PER) ? MIN_PER : div_i;
    assign wrap   = (cnt_q >= per_q - DIV_W'(1));

    always_comb begin
        st_n     = st_q;
        per_n    = per_q;
        half_n   = half_q;
        cnt_n    = cnt_q;
        clk_n    = card_clk;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        if (st_q == DIV_RUN) begin
            if (wrap) begin
                cnt_n    = '0;
                per_n    = div_ok;
                half_n   = div_ok >> 1;
                clk_n    = 1'b1;
                rise_evt = 1'b1;
            end else begin
                cnt_n = cnt_q + DIV_W'(1);
                if (cnt_n == half_q) begin
                    clk_n    = 1'b0;
                    fall_evt = 1'b1;
                end
            end
            if (stop_req && ((rise_evt && stop_high) || (fall_evt && !stop_high))) begin
                st_n = DIV_HELD;
            end
        end else if (!stop_req) begin
            st_n = DIV_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= DIV_RUN;
            per_q    <= MIN_PER;
            half_q   <= DIV_W'(1);
            cnt_q    <= DIV_W'(1);
            card_clk <= 1'b0;
            rise_p   <= 1'b0;
        end else begin
            st_q     <= st_n;
            per_q    <= per_n;
            half_q   <= half_n;
            cnt_q    <= cnt_n;
            card_clk <= clk_n;
            rise_p   <= rise_evt;
        end
    end
endmodule

// File: rtl/scetu_count.sv
module scetu_count
    import scetu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_p,
    input  logic             restart,
    input  logic [ETU_W-1:0] len,
    output logic             tick
);
    logic [ETU_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (rise_p) begin
            if (cnt_q >= len - ETU_W'(1)) begin
                cnt_q <= '0;
                tick  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + ETU_W'(1);
                tick  <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/scclk_etu_gen.sv
module scclk_etu_gen
    import scetu_pkg::*;
#(
    parameter  int NUM_IF = 2,
    parameter  int DIV_W  = 8,
    localparam int SEL_W  = (NUM_IF > 1) ? $clog2(NUM_IF) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_IF-1:0][DIV_W-1:0] div_cfg,
    input  logic [NUM_IF-1:0]           card_stop,
    input  logic [NUM_IF-1:0]           stop_lvl,
    input  logic [7:0]                  fd_cfg,
    input  logic [SEL_W-1:0]            if_sel,
    input  logic                        etu_restart,
    output logic [NUM_IF-1:0]           card_clk,
    output logic                        etu_tick
);
    logic [NUM_IF-1:0] rise_vec;
    logic              sel_rise;
    logic [ETU_W-1:0]  len_q;

    for (genvar i = 0; i < NUM_IF; i++) begin : g_slot
        scclk_div #(.DIV_W(DIV_W)) u_div (
            .clk      (clk),
            .rst      (rst),
            .div_i    (div_cfg[i]),
            .stop_req (card_stop[i]),
            .stop_high(stop_lvl[i]),
            .card_clk (card_clk[i]),
            .rise_p   (rise_vec[i])
        );
    end

    assign sel_rise = (int'(if_sel) < NUM_IF) ? rise_vec[if_sel] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= ETU_DEFAULT;
        end else begin
            len_q <= etu_len(fd_cfg_t'(fd_cfg));
        end
    end

    scetu_count u_etu (
        .clk    (clk),
        .rst    (rst),
        .rise_p (sel_rise),
        .restart(etu_restart),
        .len    (len_q),
        .tick   (etu_tick)
    );
endmodule

// File: rtl/scclk_etu_chk.sv
module scclk_etu_chk (
    input logic clk,
    input logic rst,
    input logic etu_tick,
    input logic etu_restart
);
    // R7: a bit-time tick never lasts two cycles
    p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
        etu_tick |=> !etu_tick);

    // R8: a restart suppresses the tick in the following cycle
    p_restart_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        etu_restart |=> !etu_tick);
endmodule

module scclk_div_chk (
    input logic clk,
    input logic rst,
    input logic held,
    input logic card_clk,
    input logic stop_req,
    input logic stop_high
);
    // R9: the frozen line does not move
    p_held_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (held && $past(held)) |-> $stable(card_clk));

    // R9: freezing lands on the requested level
    p_held_level_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> (card_clk == $past(stop_high)));

    // R9: freezing only happens on request
    p_held_req_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> $past(stop_req));

    // R9: dropping the request releases the clock
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (held && !stop_req) |=> !held);
endmodule

bind scclk_etu_gen scclk_etu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .etu_tick   (etu_tick),
    .etu_restart(etu_restart)
);

bind scclk_div scclk_div_chk u_div_chk (
    .clk      (clk),
    .rst      (rst),
    .held     (st_q == DIV_HELD),
    .card_clk (card_clk),
    .stop_req (stop_req),
    .stop_high(stop_high)
);

// File: tb/tb_scclk_etu_gen.sv
module tb_scclk_etu_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NIF = 2;
    localparam int DW  = 8;
    localparam int NV  = 14;

    // {reserved-code flag, fd byte, expected bit time}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h11, 12'd372},  {1'b0, 8'h12, 12'd186},
        {1'b0, 8'h13, 12'd93},   {1'b0, 8'h18, 12'd31},
        {1'b0, 8'h19, 12'd18},   {1'b0, 8'h96, 12'd16},
        {1'b0, 8'h21, 12'd558},  {1'b0, 8'h94, 12'd64},
        {1'b0, 8'h67, 12'd29},   {1'b0, 8'hD1, 12'd2048},
        {1'b1, 8'h77, 12'd5},    {1'b1, 8'h1A, 12'd372},
        {1'b1, 8'h80, 12'd372},  {1'b1, 8'h01, 12'd372}
    };

    logic clk = 1'b0;
    logic rst;
    logic [NIF-1:0][DW-1:0] div_cfg;
    logic [NIF-1:0] card_stop, stop_lvl, card_clk;
    logic [7:0] fd_cfg;
    logic [0:0] if_sel;
    logic etu_restart, etu_tick;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scclk_etu_gen #(.NUM_IF(NIF), .DIV_W(DW)) dut (
        .clk(clk), .rst(rst), .div_cfg(div_cfg), .card_stop(card_stop),
        .stop_lvl(stop_lvl), .fd_cfg(fd_cfg), .if_sel(if_sel),
        .etu_restart(etu_restart), .card_clk(card_clk), .etu_tick(etu_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // All tasks start and end positioned at a falling edge.
    task automatic wait_rise(input int idx);
        bit prv, cur;
        prv = card_clk[idx];
        for (int g = 0; g < 2000; g++) begin
            @(negedge clk);
            cur = card_clk[idx];
            if (cur && !prv) break;
            prv = cur;
        end
    endtask

    task automatic span(input int idx, output int per, output int hi);
        bit prv, cur;
        per = 0; hi = 0; prv = 1'b1;
        for (int g = 0; g < 2000; g++) begin
            per++;
            if (card_clk[idx]) hi++;
            @(negedge clk);
            cur = card_clk[idx];
            if (cur && !prv) break;
            prv = cur;
        end
    endtask

    task automatic count_to_tick(input bit prv0, output int rises, output bit after_rise);
        bit prv, cur, last_rise;
        prv = prv0; rises = 0; after_rise = 1'b0; last_rise = 1'b0;
        for (int g = 0; g < 20000; g++) begin
            cur = card_clk[if_sel];
            if (etu_tick) begin
                after_rise = last_rise;
                break;
            end
            last_rise = cur && !prv;
            if (last_rise) rises++;
            prv = cur;
            @(negedge clk);
        end
    endtask

    task automatic restart_and_count(output int rises, output bit after_rise);
        bit prv;
        prv = card_clk[if_sel];
        etu_restart = 1'b1;
        @(negedge clk);
        etu_restart = 1'b0;
        count_to_tick(prv, rises, after_rise);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int per, hi, rises, lvl, moves;
        bit ar, prv, cur;
        rst = 1'b1; div_cfg = '{8'd2, 8'd2}; card_stop = '0; stop_lvl = '0;
        fd_cfg = 8'h11; if_sel = 1'b0; etu_restart = 1'b0;
        repeat (3) @(negedge clk);
        check(card_clk == 2'b00, "R1", "clocks in reset", int'(card_clk), 0);
        check(etu_tick == 1'b0, "R1", "tick in reset", int'(etu_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check(card_clk == 2'b11, "R1", "first cycle after reset", int'(card_clk), 3);

        // R5 / R6: table of codes on slot 0 at divide-by-two
        for (int v = 0; v < NV; v++) begin
            fd_cfg = VEC[v][19:12];
            repeat (2) @(negedge clk);
            restart_and_count(rises, ar);
            if (VEC[v][20])
                check(rises == int'(VEC[v][11:0]), "R6", "reserved-code bit time", rises, int'(VEC[v][11:0]));
            else
                check(rises == int'(VEC[v][11:0]), "R5", "bit time", rises, int'(VEC[v][11:0]));
            check(ar, "R7", "tick follows completing edge", int'(ar), 1);
            @(negedge clk);
            check(!etu_tick, "R7", "tick width", int'(etu_tick), 0);
        end

        // R2: period and high time on slot 1
        div_cfg[1] = 8'd5; wait_rise(1); wait_rise(1); span(1, per, hi);
        check(per == 5, "R2", "period div5", per, 5);
        check(hi == 2, "R2", "high time div5", hi, 2);
        div_cfg[1] = 8'd0; wait_rise(1); wait_rise(1); span(1, per, hi);
        check(per == 2, "R2", "div0 treated as 2", per, 2);
        div_cfg[1] = 8'd1; wait_rise(1); wait_rise(1); span(1, per, hi);
        check(per == 2, "R2", "div1 treated as 2", per, 2);

        // R3: change divider right after a period begins
        div_cfg[1] = 8'd6; wait_rise(1); wait_rise(1);
        div_cfg[1] = 8'd3;
        span(1, per, hi);
        check(per == 6, "R3", "running period keeps old length", per, 6);
        span(1, per, hi);
        check(per == 3, "R3", "next period uses new length", per, 3);
        check(hi == 1, "R2", "high time div3", hi, 1);

        // R9 with R4: freeze slot 1 low, then high; slot 0 keeps running
        div_cfg[1] = 8'd6;
        for (int s = 0; s < 2; s++) begin
            stop_lvl[1] = s[0]; card_stop[1] = 1'b1;
            repeat (16) @(negedge clk);
            lvl = int'(card_clk[1]);
            check(lvl == s, "R9", "frozen level", lvl, s);
            moves = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (int'(card_clk[1]) != lvl) moves++;
            end
            check(moves == 0, "R9", "frozen line moves", moves, 0);
            wait_rise(0); span(0, per, hi);
            check(per == 2, "R4", "other slot period during freeze", per, 2);
            card_stop[1] = 1'b0;
            moves = 0;
            for (int k = 0; k < 14; k++) begin
                @(negedge clk);
                if (int'(card_clk[1]) != lvl) moves++;
            end
            check(moves > 0, "R9", "clock resumes after release", moves, 1);
        end

        // R10: slot 1 drives the count
        div_cfg[1] = 8'd4; if_sel = 1'b1; fd_cfg = 8'h18;
        repeat (8) @(negedge clk);
        restart_and_count(rises, ar);
        check(rises == 31 && ar, "R10", "edges of selected slot per bit", rises, 31);

        // R8: restart coincides with the completing edge
        if_sel = 1'b0; fd_cfg = 8'h77;
        repeat (2) @(negedge clk);
        restart_and_count(rises, ar);
        check(rises == 5, "R5", "short bit time", rises, 5);
        rises = 0; prv = card_clk[0];
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            cur = card_clk[0];
            if (cur && !prv) rises++;
            prv = cur;
            if (rises == 5) break;
        end
        etu_restart = 1'b1;
        @(negedge clk);
        etu_restart = 1'b0;
        check(!etu_tick, "R8", "tick after coincident restart", int'(etu_tick), 0);
        count_to_tick(1'b1, rises, ar);
        check(rises == 5, "R8", "full count after coincident restart", rises, 5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule